// File: doc/BRIEF.md
# Nested Priority Interrupt Dispatcher

This block sits behind three 32-bit interrupt status words: one main controller and two sub-controllers that cascade into it. It keeps the live enable registers for all 96 lines. It picks one vector to present to software, and it assigns every vector a programmable priority level. When software accepts the presented vector, the block saves the current enables on a small stack. It then narrows the live enables so that only vectors of strictly higher priority can interrupt the handler. When software signals end of service, the saved enables come back, filtered through the software enable image.

Software programs priorities and enable bits through a single-cycle write port. The raw pending lines come in on three status inputs. The block drives a registered vector number with a valid flag. Software then raises a take strobe to enter service and an end strobe to leave it. A priority number of 0 is the most urgent and 11 is the least urgent.

Top module: `irqd_dispatch`

## Requirements
- R1: A vector number is the module index times 32 plus the bit index: `vec_num[6:5]` carries the module (0 = main, 1 = sub-controller 1, 2 = sub-controller 2) and `vec_num[4:0]` carries the bit. Legal vectors are 0 to 95.
- R2: A vector comes from the main word if any of its enabled pending bits is set. Otherwise it comes from sub-controller 1, and failing that from sub-controller 2. With nothing enabled and pending, `vec_valid` is 0 and `vec_num` is 0.
- R3: Within one 32-bit word, the highest-numbered enabled pending bit is selected.
- R4: Main bits 0 and 1 never yield a direct vector. Sub-controller 1 is searched only while live main bit 0 is set. Sub-controller 2 is searched only while live main bit 1 is set.
- R5: `cfg_op = 2'b01` writes `cfg_prio` as the priority of vector `cfg_vec`. A value above 11 is stored as 11. After reset every vector holds priority 11.
- R6: A `svc_take` while `vec_valid` is high pushes the live enables and keeps bit v set only if the priority of vector v is numerically lower than that of the presented vector, or v is an always-open bit (R8). A take while `vec_valid` is low, or in the same cycle as `svc_end`, is ignored.
- R7: A `svc_end` with a non-empty stack pops the saved enables and sets the live enables to that word ANDed with the software enable image. A `svc_end` with an empty stack changes nothing.
- R8: Main bits 0, 1, 30 and 31 are set in the live enables and in the enable image after reset, and no service entry clears them.
- R9: `cfg_op = 2'b10` sets, and `cfg_op = 2'b11` clears, bit `cfg_vec` in both the live enables and the enable image. Any write with `cfg_vec` above 95 is ignored.
- R10: The stack holds 4 saved levels. A take while 4 levels are held is refused and leaves the live enables unchanged. It also sets `svc_overflow`, which stays set until reset.
- R11: `vec_num` and `vec_valid` are registered. They show the selection made from the pending inputs and live enables present at the previous rising clock edge.
- R12: Synchronous active-high reset clears `vec_valid`, `vec_num` and `svc_overflow`, and sets the live enables to main `C0000003`, sub-controller 1 `0`, sub-controller 2 `0`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_op | input | 2 | Write operation: 00 none, 01 priority, 10 enable, 11 disable |
| cfg_vec | input | 7 | Vector addressed by the write |
| cfg_prio | input | 4 | Priority value for a priority write |
| pend_main | input | 32 | Raw pending lines of the main controller |
| pend_sub1 | input | 32 | Raw pending lines of sub-controller 1 |
| pend_sub2 | input | 32 | Raw pending lines of sub-controller 2 |
| svc_take | input | 1 | Software accepts the presented vector |
| svc_end | input | 1 | Software finishes the innermost service level |
| vec_num | output | 7 | Selected vector number |
| vec_valid | output | 1 | A vector is presented |
| en_main | output | 32 | Live enables of the main controller |
| en_sub1 | output | 32 | Live enables of sub-controller 1 |
| en_sub2 | output | 32 | Live enables of sub-controller 2 |
| svc_overflow | output | 1 | Sticky: a take was refused because the stack was full |

## Verification
The narrowing, always-open and restore properties assume that no enable or disable write lands in the same cycle as a take or an end, so each of them is guarded on that condition. The stimulus keeps service strobes and enable writes in separate cycles. It raises `svc_take` only after `vec_valid` has been observed high, and it drives every input between clock edges with known values. Vectors above 95 are fed only to the write port, where R9 says they must be dropped.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam int WORD_W = 32;
    localparam int BIT_W  = $clog2(WORD_W);
    localparam int MOD_N  = 3;
    localparam int MOD_W  = $clog2(MOD_N);
    localparam int VEC_N  = WORD_W * MOD_N;
    localparam int VEC_W  = MOD_W + BIT_W;

    localparam int LEVELS = 12;
    localparam int PRIO_W = 4;

    // main-word bits that carry the sub-controller outputs
    localparam logic [WORD_W-1:0] CASCADE_BITS = WORD_W'((1 << (MOD_N - 1)) - 1);
    // main-word bits kept open at every priority level
    localparam logic [WORD_W-1:0] MAIN_ALWAYS  = 32'hC000_0000 | CASCADE_BITS;
    localparam logic [VEC_N-1:0]  KEEP_OPEN    = VEC_N'(MAIN_ALWAYS);

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_PRIO = 2'b01,
        OP_EN   = 2'b10,
        OP_DIS  = 2'b11
    } cfg_op_e;

    typedef struct packed {
        logic             valid;
        logic [MOD_W-1:0] module_idx;
        logic [BIT_W-1:0] bit_idx;
    } vec_sel_t;

    // index of the most significant set bit (0 when none)
    function automatic logic [BIT_W-1:0] top_bit(input logic [WORD_W-1:0] w);
        logic [BIT_W-1:0] r;
        r = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (w[i]) r = BIT_W'(i);
        end
        return r;
    endfunction

    function automatic logic vec_ok(input logic [VEC_W-1:0] v);
        return int'(v) < VEC_N;
    endfunction

endpackage

// File: rtl/irqd_prio_table.sv
module irqd_prio_table
    import irqd_pkg::*;
#(
    parameter int N    = VEC_N,
    parameter int PW   = PRIO_W,
    parameter int NLEV = LEVELS,
    parameter int VW   = VEC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [VW-1:0] wr_vec,
    input  logic [PW-1:0] wr_prio,
    input  logic [VW-1:0] rd_vec,
    output logic [PW-1:0] rd_prio,
    output logic [N-1:0]  above_mask
);

    localparam logic [PW-1:0] LOWEST = PW'(NLEV - 1);

    logic [PW-1:0] prio_q [N];
    logic [PW-1:0] wr_clamped;
    logic          wr_hit;

    assign wr_clamped = (wr_prio > LOWEST) ? LOWEST : wr_prio;
    assign wr_hit     = wr_en && (int'(wr_vec) < N);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) prio_q[i] <= LOWEST;
        end else if (wr_hit) begin
            prio_q[wr_vec] <= wr_clamped;
        end
    end

    assign rd_prio = (int'(rd_vec) < N) ? prio_q[rd_vec] : LOWEST;

    // one comparator per vector replaces a stored mask per level
    for (genvar v = 0; v < N; v++) begin : g_cmp
        assign above_mask[v] = (prio_q[v] < rd_prio);
    end

    logic          chk_wr_q;
    logic [VW-1:0] chk_vec_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            chk_wr_q  <= 1'b0;
            chk_vec_q <= '0;
        end else begin
            chk_wr_q  <= wr_hit;
            chk_vec_q <= wr_vec;
        end
    end

    AST_PRIO_CLAMPED: assert property (@(posedge clk) disable iff (rst)
        chk_wr_q |-> (prio_q[chk_vec_q] <= LOWEST)); // R5

endmodule

// File: rtl/irqd_select.sv
module irqd_select
    import irqd_pkg::*;
#(
    parameter int MN = MOD_N
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [MN-1:0][WORD_W-1:0] stat,
    output logic [VEC_W-1:0]       vec_num,
    output logic                   vec_valid
);

    logic [MN-1:0]            hit;
    logic [MN-1:0][BIT_W-1:0] idx;
    vec_sel_t                 sel_n;
    vec_sel_t                 sel_q;

    for (genvar m = 0; m < MN; m++) begin : g_mod
        assign hit[m] = |stat[m];
        assign idx[m] = top_bit(stat[m]);
    end

    // lowest module index wins: scan downwards, last hit stays
    always_comb begin
        sel_n = '0;
        for (int m = MN - 1; m >= 0; m--) begin
            if (hit[m]) begin
                sel_n.valid      = 1'b1;
                sel_n.module_idx = MOD_W'(m);
                sel_n.bit_idx    = idx[m];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sel_q <= '0;
        else     sel_q <= sel_n;
    end

    assign vec_valid = sel_q.valid;
    assign vec_num   = {sel_q.module_idx, sel_q.bit_idx};

    AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (int'(vec_num) < VEC_N)); // R1
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !vec_valid |-> (vec_num == '0)); // R2
    AST_MAIN_FIRST: assert property (@(posedge clk) disable iff (rst)
        hit[0] |=> (vec_valid && vec_num[VEC_W-1 -: MOD_W] == '0)); // R2
    AST_REG_DELAY: assert property (@(posedge clk) disable iff (rst)
        (hit == '0) |=> !vec_valid); // R11

endmodule

// File: rtl/irqd_nest_stack.sv
module irqd_nest_stack #(
    parameter int W     = 96,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_req,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top_data,
    output logic         full,
    output logic         empty,
    output logic         overflow
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  slot_q [DEPTH];
    logic [CW-1:0] cnt_q;
    logic          ovf_q;
    logic          push_ok;

    assign full     = (cnt_q == CW'(DEPTH));
    assign empty    = (cnt_q == '0);
    assign push_ok  = push_req && !full && !pop;
    assign top_data = empty ? '0 : slot_q[AW'(cnt_q - 1'b1)];
    assign overflow = ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (pop && !empty)  cnt_q <= cnt_q - 1'b1;
            else if (push_ok)   cnt_q <= cnt_q + 1'b1;
            if (push_req && full && !pop) ovf_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) slot_q[AW'(cnt_q)] <= push_data;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH)); // R10
    AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (rst)
        (push_req && full && !pop) |=> (cnt_q == CW'(DEPTH) && overflow)); // R10
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow); // R10

endmodule

// File: rtl/irqd_dispatch.sv
module irqd_dispatch
    import irqd_pkg::*;
#(
    parameter int STACK_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_op,
    input  logic [VEC_W-1:0]  cfg_vec,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic [WORD_W-1:0] pend_main,
    input  logic [WORD_W-1:0] pend_sub1,
    input  logic [WORD_W-1:0] pend_sub2,
    input  logic              svc_take,
    input  logic              svc_end,
    output logic [VEC_W-1:0]  vec_num,
    output logic              vec_valid,
    output logic [WORD_W-1:0] en_main,
    output logic [WORD_W-1:0] en_sub1,
    output logic [WORD_W-1:0] en_sub2,
    output logic              svc_overflow
);

    cfg_op_e                   op;
    logic                      cfg_ok;
    logic                      cfg_en_dis;
    logic                      cfg_live_wr;
    logic [VEC_N-1:0]          pend_all;
    logic [VEC_N-1:0]          live_q, live_n;
    logic [VEC_N-1:0]          image_q, image_n;
    logic [MOD_N-1:0][WORD_W-1:0] stat;
    logic [PRIO_W-1:0]         cur_prio;
    logic [VEC_N-1:0]          above_mask;
    logic [VEC_N-1:0]          stk_top;
    logic                      stk_full, stk_empty;
    logic                      take_req, do_push, do_pop;

    assign op          = cfg_op_e'(cfg_op);
    assign cfg_ok      = vec_ok(cfg_vec);
    assign cfg_en_dis  = (op == OP_EN) || (op == OP_DIS);
    assign cfg_live_wr = cfg_ok && cfg_en_dis;
    assign pend_all    = {pend_sub2, pend_sub1, pend_main};

    // status words: main drops cascade bits, subs gated by their cascade bit
    for (genvar m = 0; m < MOD_N; m++) begin : g_stat
        if (m == 0) begin : g_main
            assign stat[m] = pend_all[0 +: WORD_W] & live_q[0 +: WORD_W] & ~CASCADE_BITS;
        end else begin : g_sub
            assign stat[m] = pend_all[m*WORD_W +: WORD_W] & live_q[m*WORD_W +: WORD_W]
                           & {WORD_W{live_q[m-1]}};
        end
    end

    irqd_select #(.MN(MOD_N)) u_select (
        .clk       (clk),
        .rst       (rst),
        .stat      (stat),
        .vec_num   (vec_num),
        .vec_valid (vec_valid)
    );

    irqd_prio_table #(
        .N    (VEC_N),
        .PW   (PRIO_W),
        .NLEV (LEVELS),
        .VW   (VEC_W)
    ) u_prio (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (op == OP_PRIO),
        .wr_vec     (cfg_vec),
        .wr_prio    (cfg_prio),
        .rd_vec     (vec_num),
        .rd_prio    (cur_prio),
        .above_mask (above_mask)
    );

    // end of service wins over a take in the same cycle
    assign do_pop   = svc_end && !stk_empty;
    assign take_req = svc_take && vec_valid && !svc_end;
    assign do_push  = take_req && !stk_full;

    irqd_nest_stack #(
        .W     (VEC_N),
        .DEPTH (STACK_DEPTH)
    ) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push_req  (take_req),
        .pop       (do_pop),
        .push_data (live_q),
        .top_data  (stk_top),
        .full      (stk_full),
        .empty     (stk_empty),
        .overflow  (svc_overflow)
    );

    always_comb begin
        live_n  = live_q;
        image_n = image_q;
        if (do_pop)       live_n = stk_top & image_q;
        else if (do_push) live_n = live_q & (above_mask | KEEP_OPEN);
        if (cfg_ok && op == OP_EN) begin
            live_n[cfg_vec]  = 1'b1;
            image_n[cfg_vec] = 1'b1;
        end else if (cfg_ok && op == OP_DIS) begin
            live_n[cfg_vec]  = 1'b0;
            image_n[cfg_vec] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q  <= KEEP_OPEN;
            image_q <= KEEP_OPEN;
        end else begin
            live_q  <= live_n;
            image_q <= image_n;
        end
    end

    assign en_main = live_q[0 +: WORD_W];
    assign en_sub1 = live_q[WORD_W +: WORD_W];
    assign en_sub2 = live_q[2*WORD_W +: WORD_W];

    AST_NO_CASCADE_VEC: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (vec_num != VEC_W'(0) && vec_num != VEC_W'(1))); // R4
    AST_ENTRY_NARROWS: assert property (@(posedge clk) disable iff (rst)
        (do_push && !cfg_live_wr) |=> ((live_q & ~$past(live_q)) == '0)); // R6
    AST_KEEP_OPEN: assert property (@(posedge clk) disable iff (rst)
        (do_push && !cfg_live_wr) |=> ((live_q & KEEP_OPEN) == ($past(live_q) & KEEP_OPEN))); // R8
    AST_EXIT_IN_IMAGE: assert property (@(posedge clk) disable iff (rst)
        (do_pop && !cfg_live_wr) |=> ((live_q & ~image_q) == '0)); // R7
    AST_BAD_VEC_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (cfg_en_dis && !cfg_ok && !svc_take && !svc_end) |=> ($stable(live_q) && $stable(image_q))); // R9

endmodule

// File: tb/test_irqd_dispatch.sv
module test_irqd_dispatch;
    import irqd_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  cfg_op;
    logic [6:0]  cfg_vec;
    logic [3:0]  cfg_prio;
    logic [31:0] pend_main, pend_sub1, pend_sub2;
    logic        svc_take, svc_end;
    logic [6:0]  vec_num;
    logic        vec_valid;
    logic [31:0] en_main, en_sub1, en_sub2;
    logic        svc_overflow;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    irqd_dispatch #(.STACK_DEPTH(4)) i_irqd_dispatch (
        .clk          (clk),
        .rst          (rst),
        .cfg_op       (cfg_op),
        .cfg_vec      (cfg_vec),
        .cfg_prio     (cfg_prio),
        .pend_main    (pend_main),
        .pend_sub1    (pend_sub1),
        .pend_sub2    (pend_sub2),
        .svc_take     (svc_take),
        .svc_end      (svc_end),
        .vec_num      (vec_num),
        .vec_valid    (vec_valid),
        .en_main      (en_main),
        .en_sub1      (en_sub1),
        .en_sub2      (en_sub2),
        .svc_overflow (svc_overflow)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_vec(input string req, input logic v, input int num);
        chk(req, "vec_valid", 32'(vec_valid), 32'(v));
        chk(req, "vec_num", 32'(vec_num), 32'(num));
    endtask

    task automatic chk_en(input string req, input logic [31:0] m,
                          input logic [31:0] s1, input logic [31:0] s2);
        chk(req, "en_main", en_main, m);
        chk(req, "en_sub1", en_sub1, s1);
        chk(req, "en_sub2", en_sub2, s2);
    endtask

    task automatic cycle();
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [1:0] op, input int vec, input int prio);
        cfg_op = op; cfg_vec = 7'(vec); cfg_prio = 4'(prio);
        @(negedge clk);
        cfg_op = 2'b00;
    endtask

    task automatic take();
        svc_take = 1'b1;
        @(negedge clk);
        svc_take = 1'b0;
    endtask

    task automatic finish_svc();
        svc_end = 1'b1;
        @(negedge clk);
        svc_end = 1'b0;
    endtask

    task automatic set_pend(input logic [31:0] m, input logic [31:0] s1, input logic [31:0] s2);
        pend_main = m; pend_sub1 = s1; pend_sub2 = s2;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) cycle();
        rst = 1'b0;
        cycle();
        chk_vec("R12", 1'b0, 0);
        chk_en("R12", 32'hC000_0003, 32'h0, 32'h0);   // R8 always-open bits after reset
        chk("R12", "svc_overflow", 32'(svc_overflow), 32'h0);
    endtask

    task automatic t_select();
        cfg_write(2'b10, 5, 0);
        cfg_write(2'b10, 9, 0);
        cfg_write(2'b10, 40, 0);
        cfg_write(2'b10, 70, 0);
        cfg_write(2'b10, 71, 0);
        chk_en("R9", 32'hC000_0223, 32'h0000_0100, 32'h0000_00C0);
        set_pend(32'h0000_0220, 0, 0); cycle();
        chk_vec("R3", 1'b1, 9);
        set_pend(0, 32'h0000_0100, 32'h0000_0040); cycle();
        chk_vec("R1", 1'b1, 40);                       // R2 sub1 before sub2
        set_pend(0, 0, 32'h0000_0040); cycle();
        chk_vec("R2", 1'b1, 70);
        set_pend(32'h0000_0100, 0, 32'h0000_0001); cycle();
        chk_vec("R2", 1'b0, 0);                        // only disabled lines pending
        set_pend(32'h0000_0003, 0, 0); cycle();
        chk_vec("R4", 1'b0, 0);                        // cascade bits never direct
        set_pend(32'h8000_0220, 0, 0); cycle();
        chk_vec("R3", 1'b1, 31);
        set_pend(0, 0, 0); cycle();
    endtask

    task automatic t_cascade();
        cfg_write(2'b11, 0, 0);
        chk_en("R9", 32'hC000_0222, 32'h0000_0100, 32'h0000_00C0);
        set_pend(0, 32'h0000_0100, 32'h0000_0040); cycle();
        chk_vec("R4", 1'b1, 70);                       // sub1 closed off
        cfg_write(2'b10, 0, 0);
        cycle();
        chk_vec("R4", 1'b1, 40);
        set_pend(0, 0, 0); cycle();
    endtask

    task automatic t_bad_vec();
        cfg_write(2'b10, 100, 0);
        cfg_write(2'b11, 96, 0);
        cfg_write(2'b11, 127, 0);
        chk_en("R9", 32'hC000_0223, 32'h0000_0100, 32'h0000_00C0);
    endtask

    task automatic t_timing();
        set_pend(0, 0, 32'h0000_0080);
        #1;
        chk_vec("R11", 1'b0, 0);                       // not yet registered
        cycle();
        chk_vec("R11", 1'b1, 71);
        set_pend(0, 0, 0);
        #1;
        chk_vec("R11", 1'b1, 71);
        cycle();
        chk_vec("R11", 1'b0, 0);
    endtask

    task automatic t_nesting();
        cfg_write(2'b01, 5, 2);
        cfg_write(2'b01, 9, 5);
        cfg_write(2'b01, 70, 8);
        cfg_write(2'b01, 40, 14);                      // stored as 11
        set_pend(32'h0000_0200, 0, 0); cycle();
        chk_vec("R6", 1'b1, 9);
        take();
        // only vec 5 (prio 2 < 5) and the always-open bits survive
        chk_en("R6", 32'hC000_0023, 32'h0, 32'h0);
        cycle();
        chk_vec("R6", 1'b0, 0);                        // vec 9 masked during its own service
        set_pend(32'h0000_0220, 0, 0); cycle();
        chk_vec("R6", 1'b1, 5);
        cfg_write(2'b11, 70, 0);                       // disabled while in service
        take();
        chk_en("R8", 32'hC000_0003, 32'h0, 32'h0);     // nothing beats prio 2
        finish_svc();
        chk_en("R7", 32'hC000_0023, 32'h0, 32'h0);
        finish_svc();
        chk_en("R7", 32'hC000_0223, 32'h0000_0100, 32'h0000_0080);
        set_pend(0, 32'h0000_0100, 0); cycle();
        chk_vec("R5", 1'b1, 40);
        take();
        // vec 40 clamped to 11: vec 71 (default 11) must not survive
        chk_en("R5", 32'hC000_0223, 32'h0, 32'h0);
        finish_svc();
        chk_en("R7", 32'hC000_0223, 32'h0000_0100, 32'h0000_0080);
        set_pend(0, 0, 0); cycle();
    endtask

    task automatic t_overflow();
        set_pend(32'h8000_0000, 0, 0); cycle();
        chk_vec("R8", 1'b1, 31);
        for (int i = 0; i < 4; i++) take();
        chk_en("R10", 32'hC000_0223, 32'h0, 32'h0);
        chk("R10", "svc_overflow", 32'(svc_overflow), 32'h0);
        cfg_write(2'b01, 31, 3);
        take();                                        // would clear bit 9 if accepted
        chk_en("R10", 32'hC000_0223, 32'h0, 32'h0);
        chk("R10", "svc_overflow", 32'(svc_overflow), 32'h1);
        for (int i = 0; i < 4; i++) finish_svc();
        chk_en("R7", 32'hC000_0223, 32'h0000_0100, 32'h0000_0080);
        finish_svc();                                  // empty stack
        chk_en("R7", 32'hC000_0223, 32'h0000_0100, 32'h0000_0080);
        chk("R10", "svc_overflow sticky", 32'(svc_overflow), 32'h1);
        set_pend(0, 0, 0); cycle();
    endtask

    initial begin
        rst = 1'b1; cfg_op = 2'b00; cfg_vec = '0; cfg_prio = '0;
        pend_main = '0; pend_sub1 = '0; pend_sub2 = '0;
        svc_take = 1'b0; svc_end = 1'b0;
        @(negedge clk);
        t_reset();
        t_select();
        t_cascade();
        t_bad_vec();
        t_timing();
        t_nesting();
        t_overflow();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule